// File: doc/BRIEF.md
# Serial Receive Path with Error-Tagged Queue

This block recovers asynchronous serial frames from a single input line and holds the received characters in a small queue until a host collects them. An oversampling front end runs from a tick whose period is set by a divisor input. It times each bit and takes a majority of three samples around the middle of the bit. Each stored character keeps its own framing and parity verdicts. The status word shows the verdicts of the character at the head of the queue, so the host reads the status first and the data second.

Two sticky flags sit beside the queue. The overrun flag marks a character that finished arriving while the queue was full; that character is lost and the queued ones are untouched. The noise flag marks a stored character whose mid-bit samples disagreed. Both flags clear only when a status read is followed by a data read. The block gives a data-available level and a gated overrun pulse to a separate interrupt block.

Top module: `serial_rx_path`

## Requirements
- R1: Completed characters enter a queue of DEPTH (default 4) entries and leave it in arrival order, one per `data_rd` pulse, with `rd_data` valid from the cycle after the pulse; `rx_avail` is high exactly while the queue holds at least one character.
- R2: A character that completes while the queue is full is discarded and sets `status[3]` (overrun). The queued characters and their order stay unchanged.
- R3: Each overrun produces a one-cycle `ovr_irq` pulse when `rx_irq_en` is high, and no pulse when it is low.
- R4: `status[3]` (overrun) and `status[2]` (noise) clear only on a `data_rd` that follows a `stat_rd` with no `data_rd` between them. A `data_rd` without a preceding `stat_rd` leaves both set.
- R5: Each bit is sampled OVS (16) times, and its value is the majority of samples 7, 8 and 9. Any disagreement among those three in a stored frame sets `status[2]` in the cycle the character enters the queue. The character still stores its majority value.
- R6: A stop bit sampled low marks the character with a framing error. With `cfg_two_stop` high, both stop bits are checked.
- R7: With `cfg_par_en` high, a parity bit follows the data. The character is marked with a parity error when the data bits and the parity bit together have an odd count of ones for even parity (`cfg_par_odd`=0), or an even count for odd parity (`cfg_par_odd`=1). With `cfg_par_en` low, no parity bit is expected and the mark is never set.
- R8: `status[0]` is the framing mark and `status[1]` is the parity mark of the queue head. Both read as 0 while the queue is empty.
- R9: A falling edge whose mid-bit majority is high is a false start: nothing is stored and the receiver waits for the next edge.
- R10: A `data_rd` on an empty queue leaves `rd_data` at the last character read, and the queue stays empty.
- R11: `cfg_len` selects 5, 6, 7 or 8 data bits (codes 0 to 3), received least significant bit first and stored right-justified with the unused upper bits zero.
- R12: After reset, `status`, `rd_data`, `rx_avail` and `ovr_irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| baud_div | input | DIV_W | Oversample tick period minus one, in clocks |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | Two stop bits expected |
| cfg_len | input | 2 | Data bits minus five |
| rx_irq_en | input | 1 | Receive interrupt enable, gates the overrun pulse |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe, pops the queue head |
| status | output | 4 | {overrun, noise, head parity mark, head framing mark} |
| rd_data | output | 8 | Character from the last data read |
| rx_avail | output | 1 | Queue not empty |
| ovr_irq | output | 1 | One-cycle overrun pulse when enabled |

## Verification
Frames of 5 and 8 data bits, with even parity, odd parity and no parity, and with one or two stop bits, show whether the data is aligned and the frame length is handled. Corrupted parity bits and stop bits, fed in each separately, show whether each verdict stays with its own character. A one-clock glitch at mid-bit and a short low pulse separate noise that is voted out from a false start. Five characters sent back to back with no reads, followed by reads with and without a preceding status read, show whether the queued data survives an overrun, whether the interrupt gate works, and whether the flags clear only in the required read order.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic              perr;
    logic              ferr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx_s,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic [1:0] cfg_len,
  output logic       done,
  output rx_entry_t  ent,
  output logic       noisy
);
  localparam int SC_W = $clog2(OVS);
  localparam logic [SC_W-1:0] S_A   = SC_W'(OVS/2 - 1);
  localparam logic [SC_W-1:0] S_B   = SC_W'(OVS/2);
  localparam logic [SC_W-1:0] S_C   = SC_W'(OVS/2 + 1);
  localparam logic [SC_W-1:0] S_END = SC_W'(OVS - 1);

  rx_state_e         st;
  logic [SC_W-1:0]   sc;
  logic [2:0]        bidx;
  logic              sa, sb;
  logic [CHAR_W-1:0] sh;
  logic              par_bit, ferr_acc, nz_acc;
  logic              maj, dis, last_bit;
  logic [2:0]        nbits_m1;
  logic [CHAR_W-1:0] data_fin;

  assign maj      = (sa & sb) | (sa & rx_s) | (sb & rx_s);
  assign dis      = ~((sa & sb & rx_s) | ~(sa | sb | rx_s));
  assign nbits_m1 = {1'b1, cfg_len};
  assign data_fin = sh >> (~cfg_len);
  assign last_bit = (st == ST_STOP2) || (st == ST_STOP1 && !cfg_two_stop);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      sc       <= '0;
      bidx     <= '0;
      sa       <= 1'b1;
      sb       <= 1'b1;
      sh       <= '0;
      par_bit  <= 1'b0;
      ferr_acc <= 1'b0;
      nz_acc   <= 1'b0;
      done     <= 1'b0;
      ent      <= '0;
      noisy    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == ST_IDLE) begin
          if (!rx_s) begin
            st       <= ST_START;
            sc       <= SC_W'(1);
            ferr_acc <= 1'b0;
            nz_acc   <= 1'b0;
          end
        end else begin
          sc <= (sc == S_END) ? '0 : sc + 1'b1;
          if (sc == S_A) sa <= rx_s;
          if (sc == S_B) sb <= rx_s;
          if (sc == S_C) begin
            unique case (st)
              ST_START: if (maj) st <= ST_IDLE;
                        else nz_acc <= nz_acc | dis;
              ST_DATA: begin
                sh     <= {maj, sh[CHAR_W-1:1]};
                nz_acc <= nz_acc | dis;
              end
              ST_PAR: begin
                par_bit <= maj;
                nz_acc  <= nz_acc | dis;
              end
              default: begin
                if (last_bit) begin
                  st        <= ST_IDLE;
                  done      <= 1'b1;
                  ent.data  <= data_fin;
                  ent.ferr  <= ferr_acc | ~maj;
                  ent.perr  <= cfg_par_en & ((^data_fin ^ par_bit) != cfg_par_odd);
                  noisy     <= nz_acc | dis;
                end else begin
                  ferr_acc <= ~maj;
                  nz_acc   <= nz_acc | dis;
                end
              end
            endcase
          end
          if (sc == S_END) begin
            unique case (st)
              ST_START: begin st <= ST_DATA; bidx <= '0; end
              ST_DATA:
                if (bidx == nbits_m1) st <= cfg_par_en ? ST_PAR : ST_STOP1;
                else bidx <= bidx + 1'b1;
              ST_PAR:   st <= ST_STOP1;
              ST_STOP1: st <= ST_STOP2;
              default:  st <= st;
            endcase
          end
        end
      end
    end
  end

  assert_false_start_R9: assert property (@(posedge clk) disable iff (rst)
    (tick && st == ST_START && sc == S_C && maj) |=> (st == ST_IDLE && !done));
  assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  rx_entry_t         wdata,
  input  logic              pop,
  output rx_entry_t         head,
  output logic [CHAR_W-1:0] rd_q,
  output logic              empty,
  output logic              full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_pop, do_push;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_push = push & ~full;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      rd_q  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop) begin
        rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
        rd_q <= mem[rptr].data;
      end
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  assert_push_room_R2: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> count == $past(count) + 1'b1);
  assert_empty_read_R10: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> ($stable(rd_q) && empty));
endmodule

// File: rtl/serial_rx_path.sv
module serial_rx_path
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int OVS   = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_in,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_two_stop,
  input  logic [1:0]       cfg_len,
  input  logic             rx_irq_en,
  input  logic             stat_rd,
  input  logic             data_rd,
  output logic [3:0]       status,
  output logic [7:0]       rd_data,
  output logic             rx_avail,
  output logic             ovr_irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             sync1, sync2, tick;
  logic             s_done, s_noisy;
  rx_entry_t        s_ent, head;
  logic             f_empty, f_full, push, ovr_set;
  logic [CNT_W-1:0] f_cnt;
  logic             armed, ovr_flag, noise_flag, rd_clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= rx_in;
      sync2 <= sync1;
    end
  end

  rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div(baud_div), .tick(tick)
  );

  rx_frame_sampler #(.OVS(OVS)) u_samp (
    .clk(clk), .rst(rst), .tick(tick), .rx_s(sync2),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_len(cfg_len),
    .done(s_done), .ent(s_ent), .noisy(s_noisy)
  );

  assign push    = s_done & ~f_full;
  assign ovr_set = s_done & f_full;

  rx_err_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wdata(s_ent), .pop(data_rd),
    .head(head), .rd_q(rd_data), .empty(f_empty), .full(f_full), .count(f_cnt)
  );

  assign rd_clear = data_rd & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      ovr_flag   <= 1'b0;
      noise_flag <= 1'b0;
      ovr_irq    <= 1'b0;
    end else begin
      if (data_rd)      armed <= 1'b0;
      else if (stat_rd) armed <= 1'b1;
      if (ovr_set)       ovr_flag <= 1'b1;
      else if (rd_clear) ovr_flag <= 1'b0;
      if (push && s_noisy) noise_flag <= 1'b1;
      else if (rd_clear)   noise_flag <= 1'b0;
      ovr_irq <= ovr_set & rx_irq_en;
    end
  end

  assign status   = {ovr_flag, noise_flag, head.perr & ~f_empty, head.ferr & ~f_empty};
  assign rx_avail = ~f_empty;

  assert_ovr_keeps_R2: assert property (@(posedge clk) disable iff (rst)
    (ovr_set && !data_rd) |=> f_cnt == $past(f_cnt));
  assert_ovr_irq_gate_R3: assert property (@(posedge clk) disable iff (rst)
    ovr_irq |-> ($past(rx_irq_en) && ovr_flag));
  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(ovr_flag) || $fell(noise_flag)) |-> $past(armed && data_rd));
  assert_noise_set_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(noise_flag) |-> ($past(push) && rx_avail));
endmodule

// File: tb/tb_serial_rx_path.sv
`timescale 1ns/1ps
module tb_serial_rx_path;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, rx_in = 1'b1;
  logic [15:0] baud_div = '0;
  logic       cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, rx_irq_en = 1;
  logic [1:0] cfg_len = 2'd3;
  logic       stat_rd = 0, data_rd = 0;
  logic [3:0] status;
  logic [7:0] rd_data;
  logic       rx_avail, ovr_irq;

  serial_rx_path dut (
    .clk(clk), .rst(rst), .rx_in(rx_in), .baud_div(baud_div),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .cfg_len(cfg_len), .rx_irq_en(rx_irq_en), .stat_rd(stat_rd), .data_rd(data_rd),
    .status(status), .rd_data(rd_data), .rx_avail(rx_avail), .ovr_irq(ovr_irq)
  );

  int checks = 0, errors = 0, irq_cnt = 0;
  bit finished = 0;
  logic [9:0] q[$];               // model queue: {perr, ferr, data}
  logic exp_ovr = 0, exp_noise = 0;
  logic [7:0] last_rd = 8'h00;

  always @(posedge clk) if (!rst && ovr_irq) irq_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b, input bit glitch);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      rx_in = (glitch && c == 9) ? ~b : b;
    end
  endtask

  task automatic send(input logic [7:0] d, input int gbit, input bit bad1, input bit bad2,
                      input bit flip);
    int n;
    logic [7:0] dm;
    logic fe, pe;
    n  = 5 + int'(cfg_len);
    dm = d & 8'((1 << n) - 1);
    drive_bit(1'b0, 0);
    for (int i = 0; i < n; i++) drive_bit(dm[i], i == gbit);
    if (cfg_par_en) drive_bit(^dm ^ cfg_par_odd ^ flip, 0);
    drive_bit(~bad1, 0);
    if (cfg_two_stop) drive_bit(~bad2, 0);
    repeat (24) begin @(negedge clk); rx_in = 1'b1; end
    fe = bad1 | (cfg_two_stop & bad2);
    pe = cfg_par_en & flip;
    if (q.size() < 4) begin
      q.push_back({pe, fe, dm});
      if (gbit >= 0) exp_noise = 1;
    end else exp_ovr = 1;
  endtask

  task automatic chk_status(input string req);
    logic [1:0] hf;
    hf = (q.size() > 0) ? q[0][9:8] : 2'b00;
    chk({req, " status"}, 32'(status), 32'({exp_ovr, exp_noise, hf[1], hf[0]}));
    chk({req, " rx_avail"}, 32'(rx_avail), 32'(q.size() > 0));
  endtask

  task automatic rd(input string req, input bit with_stat);
    logic [7:0] e;
    if (with_stat) begin
      @(negedge clk); stat_rd = 1;
      @(negedge clk); stat_rd = 0;
    end
    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
    if (q.size() > 0) begin
      e = q[0][7:0];
      void'(q.pop_front());
    end else e = last_rd;
    last_rd = e;
    if (with_stat) begin exp_ovr = 0; exp_noise = 0; end
    chk({req, " rd_data"}, 32'(rd_data), 32'(e));
    chk_status(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 status", 32'(status), 0);
    chk("R12 rd_data", 32'(rd_data), 0);
    chk("R12 rx_avail", 32'(rx_avail), 0);
    chk("R12 ovr_irq", 32'(ovr_irq), 0);

    // R1 ordering, 8-bit frames
    send(8'hA5, -1, 0, 0, 0);
    send(8'h3C, -1, 0, 0, 0);
    chk_status("R1");
    rd("R1", 1);
    rd("R1", 1);

    // R11 five-bit word
    cfg_len = 2'd0;
    send(8'hFF, -1, 0, 0, 0);
    send(8'h0A, -1, 0, 0, 0);
    rd("R11", 1);
    rd("R11", 1);
    cfg_len = 2'd3;

    // R7 parity, R8 head flags
    cfg_par_en = 1; cfg_par_odd = 0;
    send(8'h96, -1, 0, 0, 0);
    send(8'h96, -1, 0, 0, 1);
    chk_status("R8");
    rd("R7", 1);
    chk_status("R7");
    rd("R7", 1);
    cfg_par_odd = 1;
    send(8'h01, -1, 0, 0, 0);
    send(8'h01, -1, 0, 0, 1);
    rd("R7", 1);
    rd("R7", 1);
    cfg_par_en = 0;

    // R6 framing
    send(8'h77, -1, 1, 0, 0);
    chk_status("R6");
    rd("R6", 1);
    cfg_two_stop = 1;
    send(8'hC3, -1, 0, 1, 0);
    send(8'hC4, -1, 0, 0, 0);
    chk_status("R6");
    rd("R6", 1);
    rd("R6", 1);
    cfg_two_stop = 0;

    // R5 noise, R4 read order
    send(8'h5A, 3, 0, 0, 0);
    send(8'h12, -1, 0, 0, 0);
    chk_status("R5");
    rd("R4", 0);
    rd("R4", 1);

    // R9 false start
    repeat (4) begin @(negedge clk); rx_in = 0; end
    repeat (60) begin @(negedge clk); rx_in = 1; end
    chk_status("R9");

    // R2 overrun, R3 irq
    irq_cnt = 0;
    for (int k = 1; k <= 5; k++) send(8'(k * 8'h11), -1, 0, 0, 0);
    chk_status("R2");
    chk("R3 irq count", 32'(irq_cnt), 1);
    rd("R4", 0);
    for (int k = 0; k < 3; k++) rd("R2", 0);
    rd("R10", 0);
    chk("R10 rx_avail", 32'(rx_avail), 0);
    rd("R4", 1);

    // R3 disabled gate
    rx_irq_en = 0;
    irq_cnt = 0;
    for (int k = 0; k < 5; k++) send(8'(8'hE0 + k), -1, 0, 0, 0);
    chk("R3 irq masked", 32'(irq_cnt), 0);
    chk_status("R3");
    for (int k = 0; k < 4; k++) rd("R2", 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule